// File: doc/BRIEF.md
# Boundary Scan Chain

This block is the boundary register of a test access port: a row of scan cells placed between the system core and the device pins. Each cell has two parts. A serial stage is loaded on the rising test clock, either by parallel capture or by a one-bit shift. An update latch takes a copy of the serial stage on the falling test clock. A TAP controller outside this block drives the Capture-DR, Shift-DR and Update-DR state strobes and a decoded two-bit instruction code. This block uses them to decide when its cells capture, shift, update, and when they take over the pins.

The chain holds `IN_CELLS` input cells, which sit between the pin inputs and the core inputs, and `OUT_CELLS` output cells, which sit between the core outputs and the pin outputs. In normal operation, and under the sample and preload instructions, the cells are transparent. The core drives the pins, and the pins feed the core. Under the external-test instruction, the update latches drive the pins, and the core sees only the latched input-cell values. This keeps the core away from whatever arrives at the pins. The serial output `bsr_tdo` goes to the TAP's output multiplexer. `bsr_sel` tells that multiplexer that this register is the one in the scan path.

Top module: `bscan_chain`

## Requirements
- R1: `bsr_sel` is 1 exactly when `instr_sel` is 1 (sample), 2 (preload) or 3 (external test). It is 0 for code 0, which stands for any other instruction.
- R2: On each rising `tck` with `shift_dr` high and the chain selected, every cell takes the value of its neighbour one place toward the TDI end. Cell L-1 takes `tdi`. `bsr_tdo` always shows cell 0. A bit entered at `tdi` therefore appears at `bsr_tdo` after L = IN_CELLS+OUT_CELLS shifts.
- R3: On a rising `tck` with `capture_dr` high and the chain selected, cells 0..IN_CELLS-1 load `pin_in` (bit i into cell i). Cells IN_CELLS..L-1 load the current `pin_out` (bit j into cell IN_CELLS+j).
- R4: On a falling `tck` with `update_dr` high and the chain selected, every update latch loads its serial stage. This applies under sample, preload and external test.
- R5: When `instr_sel` is not 3, `pin_out` equals `core_out` and `core_in` equals `pin_in` at all times, whatever the scan activity.
- R6: Under external test, `pin_out[j]` is the update latch of cell IN_CELLS+j. `pin_out` changes only on a falling `tck` that loads or clears the latches.
- R7: Under external test, `core_in[i]` is the update latch of cell i and does not follow `pin_in`.
- R8: A falling `tck` with `tlr` high clears all update latches. `trst_n` low clears the serial stages and the update latches at once, without waiting for a clock edge.
- R9: When `instr_sel` is 0, the capture, shift and update strobes have no effect on the serial stages or the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| instr_sel | input | 2 | Decoded instruction: 0 other, 1 sample, 2 preload, 3 external test |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| bsr_tdo | output | 1 | Serial data out (cell 0) |
| bsr_sel | output | 1 | Boundary register is in the scan path |
| core_out | input | OUT_CELLS | Values the core drives toward the pins |
| pin_out | output | OUT_CELLS | Values driven to the output pins |
| pin_in | input | IN_CELLS | Values received at the input pins |
| core_in | output | IN_CELLS | Values presented to the core inputs |

## Verification
Capture and shift results are registered on a rising edge. They are due at `bsr_tdo` one rising edge after the strobe is applied, so the bench checks them one nanosecond after that edge, once per bit. Update and Test-Logic-Reset results are registered on a falling edge. They are due half a period after the strobe is set, so the bench checks `pin_out` both shortly before and shortly after that falling edge to show it moves on that edge alone. The transparent paths and the asynchronous reset are combinational with respect to their inputs, so they are checked within the same cycle, with no edge in between.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    INS_OTHER   = 2'd0,
    INS_SAMPLE  = 2'd1,
    INS_PRELOAD = 2'd2,
    INS_EXTEST  = 2'd3
  } bs_instr_e;

  // Any of the three boundary instructions puts the chain in the scan path.
  function automatic logic chain_selected(input bs_instr_e code);
    return (code == INS_SAMPLE) || (code == INS_PRELOAD) || (code == INS_EXTEST);
  endfunction

  // Only external test disconnects the core from the pins.
  function automatic logic core_isolated(input bs_instr_e code);
    return code == INS_EXTEST;
  endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage #(
  parameter int IN_CELLS  = 4,
  parameter int OUT_CELLS = 4,
  localparam int LEN = IN_CELLS + OUT_CELLS
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 cap_en,
  input  logic                 shift_en,
  input  logic                 tdi,
  input  logic [IN_CELLS-1:0]  cap_pins,
  input  logic [OUT_CELLS-1:0] cap_drive,
  output logic [LEN-1:0]       sr_q
);

  logic [LEN-1:0] cap_val;
  logic [LEN-1:0] shift_val;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i < IN_CELLS) begin : g_in
      assign cap_val[i] = cap_pins[i];
    end else begin : g_out
      assign cap_val[i] = cap_drive[i-IN_CELLS];
    end
    if (i == LEN-1) begin : g_head
      assign shift_val[i] = tdi;
    end else begin : g_link
      assign shift_val[i] = sr_q[i+1];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sr_q <= '0;
    else if (cap_en)   sr_q <= cap_val;
    else if (shift_en) sr_q <= shift_val;
  end

  AST_SHIFT_HEAD: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !cap_en) |=> sr_q[LEN-1] == $past(tdi)); // R2
  AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !cap_en) |=> sr_q[LEN-2:0] == $past(sr_q[LEN-1:1])); // R2
  AST_CAPTURE_PINS: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> sr_q[IN_CELLS-1:0] == $past(cap_pins)); // R3
  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (!cap_en && !shift_en) |=> $stable(sr_q)); // R9

endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank #(
  parameter int LEN = 8
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           clr,
  input  logic           load,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q
);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)   q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end

  AST_UPDATE_LOAD: assert property (@(negedge tck) disable iff (!trst_n)
    (load && !clr) |=> q == $past(d)); // R4
  AST_TLR_CLEAR: assert property (@(negedge tck) disable iff (!trst_n)
    clr |=> q == '0); // R8
  AST_LATCH_HOLD: assert property (@(negedge tck) disable iff (!trst_n)
    (!load && !clr) |=> $stable(q)); // R9

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux #(
  parameter int IN_CELLS  = 4,
  parameter int OUT_CELLS = 4,
  localparam int LEN = IN_CELLS + OUT_CELLS
) (
  input  logic                 isolate,
  input  logic [LEN-1:0]       upd_q,
  input  logic [OUT_CELLS-1:0] core_out,
  input  logic [IN_CELLS-1:0]  pin_in,
  output logic [OUT_CELLS-1:0] pin_out,
  output logic [IN_CELLS-1:0]  core_in
);

  for (genvar j = 0; j < OUT_CELLS; j++) begin : g_drive
    assign pin_out[j] = isolate ? upd_q[IN_CELLS+j] : core_out[j];
  end

  for (genvar i = 0; i < IN_CELLS; i++) begin : g_recv
    assign core_in[i] = isolate ? upd_q[i] : pin_in[i];
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int IN_CELLS  = 4,
  parameter int OUT_CELLS = 4
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tlr,
  input  logic [1:0]           instr_sel,
  input  logic                 capture_dr,
  input  logic                 shift_dr,
  input  logic                 update_dr,
  input  logic                 tdi,
  output logic                 bsr_tdo,
  output logic                 bsr_sel,
  input  logic [OUT_CELLS-1:0] core_out,
  output logic [OUT_CELLS-1:0] pin_out,
  input  logic [IN_CELLS-1:0]  pin_in,
  output logic [IN_CELLS-1:0]  core_in
);
  import bscan_pkg::*;

  localparam int LEN = IN_CELLS + OUT_CELLS;

  bs_instr_e      mode;
  logic           isolate;
  logic           cap_en;
  logic           shift_en;
  logic           upd_load;
  logic           tlr_clr;
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] upd_q;

  assign mode     = bs_instr_e'(instr_sel);
  assign bsr_sel  = chain_selected(mode);
  assign isolate  = core_isolated(mode);
  assign cap_en   = bsr_sel && capture_dr;
  assign shift_en = bsr_sel && shift_dr;
  assign upd_load = bsr_sel && update_dr;
  assign tlr_clr  = tlr;
  assign bsr_tdo  = sr_q[0];

  bscan_shift_stage #(.IN_CELLS(IN_CELLS), .OUT_CELLS(OUT_CELLS)) u_shift (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .tdi      (tdi),
    .cap_pins (pin_in),
    .cap_drive(pin_out),
    .sr_q     (sr_q)
  );

  bscan_update_bank #(.LEN(LEN)) u_update (
    .tck   (tck),
    .trst_n(trst_n),
    .clr   (tlr_clr),
    .load  (upd_load),
    .d     (sr_q),
    .q     (upd_q)
  );

  bscan_pin_mux #(.IN_CELLS(IN_CELLS), .OUT_CELLS(OUT_CELLS)) u_mux (
    .isolate (isolate),
    .upd_q   (upd_q),
    .core_out(core_out),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .core_in (core_in)
  );

  AST_PIN_STEADY: assert property (@(negedge tck) disable iff (!trst_n)
    (isolate && !upd_load && !tlr_clr) ##1 isolate |-> $stable(pin_out)); // R6
  AST_CAPTURE_DRIVE: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> sr_q[LEN-1:IN_CELLS] == $past(pin_out)); // R3
  AST_NO_SCAN_WHEN_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
    (!bsr_sel) |=> $stable(sr_q)); // R9

endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int TCK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + NO;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tlr = 1'b0;
  logic [1:0]    instr_sel = 2'd0;
  logic          capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic          bsr_tdo, bsr_sel;
  logic [NO-1:0] core_out = 4'h5, pin_out;
  logic [NI-1:0] pin_in = 4'hA, core_in;

  int nchk = 0;
  int nerr = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  bscan_chain #(.IN_CELLS(NI), .OUT_CELLS(NO)) i_bscan_chain (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .instr_sel(instr_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .bsr_tdo(bsr_tdo), .bsr_sel(bsr_sel),
    .core_out(core_out), .pin_out(pin_out), .pin_in(pin_in), .core_in(core_in)
  );

  // {instr, core_out, pin_in, expected pin_out, expected core_in}; latches hold out=C, in=6
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd1, 4'h3, 4'h9, 4'h3, 4'h9},
    {2'd2, 4'hA, 4'h5, 4'hA, 4'h5},
    {2'd0, 4'hF, 4'h0, 4'hF, 4'h0},
    {2'd3, 4'h3, 4'h9, 4'hC, 4'h6},
    {2'd3, 4'hA, 4'h5, 4'hC, 4'h6},
    {2'd1, 4'h0, 4'hF, 4'h0, 4'hF}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  // Shift din in (bit 0 first) while checking bsr_tdo against dexp when chk is set.
  task automatic shift_word(input logic [L-1:0] din, input logic [L-1:0] dexp,
                            input logic chk, input string tag);
    for (int i = 0; i < L; i++) begin
      if (chk) check(32'(bsr_tdo), 32'(dexp[i]), tag);
      tdi = din[i];
      shift_dr = 1'b1;
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic pulse_update();
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state
    step(); step();
    check(32'(bsr_tdo), 0, "R8 reset tdo");
    check(32'(bsr_sel), 0, "R1 other code not selected");
    check(32'(pin_out), 32'h5, "R5 reset pin_out");
    check(32'(core_in), 32'hA, "R5 reset core_in");
    trst_n = 1'b1;
    step();

    // Preload the latches with C6 and confirm the pins are untouched
    instr_sel = 2'd2;
    #1 check(32'(bsr_sel), 1, "R1 preload selects chain");
    shift_word(8'hC6, 8'h00, 1'b1, "R2 shift from reset");
    check(32'(pin_out), 32'h5, "R5 preload shift leaves pins");
    pulse_update();
    check(32'(pin_out), 32'h5, "R5 preload update leaves pins");
    check(32'(core_in), 32'hA, "R5 preload update leaves core");

    // Table walk over instruction modes
    for (int v = 0; v < NVEC; v++) begin
      instr_sel = VEC[v][17:16];
      core_out  = VEC[v][15:12];
      pin_in    = VEC[v][11:8];
      #2;
      check(32'(bsr_sel), 32'(VEC[v][17:16] != 2'd0), "R1 select vector");
      check(32'(pin_out), 32'(VEC[v][7:4]), "R5/R6 pin_out vector");
      check(32'(core_in), 32'(VEC[v][3:0]), "R5/R7 core_in vector");
    end
    step();

    // External test: pins move only on the update falling edge
    instr_sel = 2'd3;
    shift_word(8'h3B, 8'h00, 1'b0, "");
    check(32'(pin_out), 32'hC, "R6 pins hold during shift");
    update_dr = 1'b1;
    #2 check(32'(pin_out), 32'hC, "R6 pins hold before falling edge");
    @(negedge tck); #1;
    check(32'(pin_out), 32'h3, "R6 pins after falling edge");
    check(32'(core_in), 32'hB, "R7 core_in from latches");
    pin_in = 4'h9;
    #1 check(32'(core_in), 32'hB, "R7 core ignores pins");
    step();
    update_dr = 1'b0;

    // External test capture: {pin_out=3, pin_in=9}
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
    shift_word(8'hA5, 8'h39, 1'b1, "R3 extest capture readout");
    shift_word(8'h00, 8'hA5, 1'b1, "R2 serial delay of chain length");

    // Sample capture: {core_out=6, pin_in=E}
    instr_sel = 2'd1;
    core_out = 4'h6;
    pin_in = 4'hE;
    #1;
    check(32'(pin_out), 32'h6, "R5 sample passes core_out");
    check(32'(core_in), 32'hE, "R5 sample passes pin_in");
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
    shift_word(8'h00, 8'h6E, 1'b1, "R3 sample capture readout");

    // Other instruction: strobes ignored (serial stage is 00, latches 3B)
    instr_sel = 2'd0;
    pin_in = 4'hF;
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
    check(32'(bsr_tdo), 0, "R9 capture ignored");
    shift_word(8'hFF, 8'h00, 1'b1, "R9 shift ignored");
    check(32'(bsr_tdo), 0, "R9 shift ignored end");
    pulse_update();
    instr_sel = 2'd3;
    #1;
    check(32'(pin_out), 32'h3, "R9 update ignored pins");
    check(32'(core_in), 32'hB, "R9 update ignored core");

    // Test-Logic-Reset clears the latches on the falling edge
    tlr = 1'b1;
    #2 check(32'(pin_out), 32'h3, "R8 clear waits for falling edge");
    step();
    tlr = 1'b0;
    check(32'(pin_out), 32'h0, "R8 tlr clears output latches");
    check(32'(core_in), 32'h0, "R8 tlr clears input latches");

    // Asynchronous test reset
    shift_word(8'hFF, 8'h00, 1'b0, "");
    pulse_update();
    check(32'(pin_out), 32'hF, "R4 extest update loads latches");
    check(32'(bsr_tdo), 1, "R2 stage filled with ones");
    #2 trst_n = 1'b0;
    #1;
    check(32'(pin_out), 32'h0, "R8 async reset latches");
    check(32'(core_in), 32'h0, "R8 async reset input latches");
    check(32'(bsr_tdo), 0, "R8 async reset serial stage");
    step();
    trst_n = 1'b1;
    step();

    finish_run();
  end

endmodule